// File: doc/BRIEF.md
# Block-Header Issue Grouping and Predication Decoder

This block takes the control fields of a per-block instruction header and turns them into three per-slot masks for the seven instruction slots that follow the header. The decode mask says which slots hold instructions and which hold in-block constant data. The group-start mask marks where each parallel issue group begins. The execute-enable mask says whether each decoded slot is allowed to run under the block's predicate.

The header supplies several fields together:

- a count of tail slots set aside for data;
- one break bit per slot;
- one predication bit per slot;
- a selector that picks one bit out of a 16-bit flag register;
- a sense bit that inverts the predicate test.

A sequential-mode input makes every decoded slot start its own group. An implementation uses it when it does not issue slots in parallel. The alternate-instruction-set bit is not interpreted here; the block only passes it through.

All results are registered. They appear one clock after `hdr_valid`, together with a one-cycle `out_valid` pulse, and they hold until the next header arrives.

Top module: `vliw_hdr_ctl`

## Requirements
- R1: With reserve count k on `reserve_cnt`, `decode_mask` has exactly bits 0 to 6-k set. Bit i stands for slot i+1, so the k highest-numbered slots are reserved. A count of 7 reserves every slot.
- R2: A reserved slot (decode bit 0) always reads 0 in `group_start` and `exec_en`, whatever its break and predication bits are.
- R3: When `seq_mode` is 0, a decoded slot 2 to 7 (bit i, i>0) starts a group exactly when its break bit `brk_bits[i]` is 1.
- R4: Slot 1 (bit 0) always starts a group when it is decoded, even if its break bit is 0.
- R5: When `seq_mode` is 1, `group_start` equals `decode_mask`, whatever the break bits are.
- R6: A decoded slot whose predication bit `pred_bits[i]` is 0 always has `exec_en[i]` = 1.
- R7: With `sense` = 0, a decoded predicated slot is enabled exactly when `flag_reg[flag_sel]` is 1.
- R8: With `sense` = 1, a decoded predicated slot is enabled exactly when `flag_reg[flag_sel]` is 0.
- R9: The outputs update on the clock edge that samples `hdr_valid` = 1, and `out_valid` is high for exactly that following cycle. While `hdr_valid` is 0 the masks hold their values and `out_valid` is 0.
- R10: Synchronous reset clears `out_valid`, all three masks and `alt_out` to 0.
- R11: `alt_out` carries the `alt_in` value of the last accepted header, with the same latency as the masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header fields are valid this cycle |
| seq_mode | input | 1 | 1 = every decoded slot starts its own group |
| brk_bits | input | 7 | Break bit per slot, bit i = slot i+1 |
| pred_bits | input | 7 | Predication bit per slot, bit i = slot i+1 |
| flag_sel | input | 4 | Index of the predicate flag |
| sense | input | 1 | 0 = run when the flag is set, 1 = run when it is clear |
| reserve_cnt | input | 3 | Number of tail slots reserved as data |
| alt_in | input | 1 | Alternate instruction-set bit, passed through |
| flag_reg | input | 16 | Current flag register contents |
| out_valid | output | 1 | One-cycle pulse marking fresh masks |
| decode_mask | output | 7 | 1 = slot is decoded as an instruction |
| group_start | output | 7 | 1 = slot opens a new issue group |
| exec_en | output | 7 | 1 = slot is allowed to execute |
| alt_out | output | 1 | Registered alternate instruction-set bit |

## Verification
The bench builds the block with its default parameters: seven slots, a 16-entry flag register and a 3-bit reserve count. This reaches every reserve count from zero up to the case where all seven slots are reserved. It also lets the flag selector index both ends of the flag register, bits 0 and 15, as well as bits in the middle. The vectors place break and predication bits on reserved slots so that the masking of R2 can be observed. They exercise both sense values with the selected flag at 0 and at 1. A header arriving in sequential mode is placed between headers arriving in grouped mode.

// File: rtl/vliw_hdr_pkg.sv
package vliw_hdr_pkg;

    localparam int DEF_SLOTS = 7;
    localparam int DEF_FLAGS = 16;

    typedef enum logic {
        ISSUE_GROUPED    = 1'b0,
        ISSUE_SEQUENTIAL = 1'b1
    } issue_mode_e;

    // Predicate outcome for one selected flag and the block's sense bit.
    function automatic logic pred_pass(input logic flag_bit, input logic inv);
        return flag_bit ^ inv;
    endfunction

endpackage

// File: rtl/slot_reserve.sv
module slot_reserve #(
    parameter int NUM_SLOTS = 7,
    parameter int CNT_W     = 3
) (
    input  logic [CNT_W-1:0]     reserve_cnt,
    output logic [NUM_SLOTS-1:0] decode_mask
);
    // Slot i stays an instruction while it lies below the reserved tail.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign decode_mask[i] = (32'(i) + 32'(reserve_cnt)) < 32'(NUM_SLOTS);
    end
endmodule

// File: rtl/group_mark.sv
module group_mark
    import vliw_hdr_pkg::*;
#(
    parameter int NUM_SLOTS = 7
) (
    input  logic [NUM_SLOTS-1:0] decode_mask,
    input  logic [NUM_SLOTS-1:0] brk_bits,
    input  issue_mode_e          mode,
    output logic [NUM_SLOTS-1:0] group_start
);
    logic force_split;
    assign force_split = (mode == ISSUE_SEQUENTIAL);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        if (i == 0) begin : g_first
            assign group_start[i] = decode_mask[i];
        end else begin : g_rest
            assign group_start[i] = decode_mask[i] & (brk_bits[i] | force_split);
        end
    end
endmodule

// File: rtl/pred_gate.sv
module pred_gate
    import vliw_hdr_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    parameter int NUM_FLAGS = 16,
    localparam int SEL_W    = $clog2(NUM_FLAGS)
) (
    input  logic [NUM_FLAGS-1:0] flag_reg,
    input  logic [SEL_W-1:0]     flag_sel,
    input  logic                 sense,
    input  logic [NUM_SLOTS-1:0] pred_bits,
    input  logic [NUM_SLOTS-1:0] decode_mask,
    output logic [NUM_SLOTS-1:0] exec_en
);
    logic cond_ok;
    assign cond_ok = pred_pass(flag_reg[flag_sel], sense);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign exec_en[i] = decode_mask[i] & (~pred_bits[i] | cond_ok);
    end
endmodule

// File: rtl/vliw_hdr_ctl.sv
module vliw_hdr_ctl
    import vliw_hdr_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int NUM_FLAGS = DEF_FLAGS,
    localparam int SEL_W    = $clog2(NUM_FLAGS),
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hdr_valid,
    input  logic                 seq_mode,
    input  logic [NUM_SLOTS-1:0] brk_bits,
    input  logic [NUM_SLOTS-1:0] pred_bits,
    input  logic [SEL_W-1:0]     flag_sel,
    input  logic                 sense,
    input  logic [CNT_W-1:0]     reserve_cnt,
    input  logic                 alt_in,
    input  logic [NUM_FLAGS-1:0] flag_reg,
    output logic                 out_valid,
    output logic [NUM_SLOTS-1:0] decode_mask,
    output logic [NUM_SLOTS-1:0] group_start,
    output logic [NUM_SLOTS-1:0] exec_en,
    output logic                 alt_out
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] dec;
        logic [NUM_SLOTS-1:0] grp;
        logic [NUM_SLOTS-1:0] exe;
        logic                 alt;
    } slot_ctl_t;

    issue_mode_e          mode;
    logic [NUM_SLOTS-1:0] dec_d, grp_d, exe_d;
    slot_ctl_t            ctl_d, ctl_q;
    logic                 vld_q;

    assign mode = seq_mode ? ISSUE_SEQUENTIAL : ISSUE_GROUPED;

    slot_reserve #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_reserve (
        .reserve_cnt (reserve_cnt),
        .decode_mask (dec_d)
    );

    group_mark #(.NUM_SLOTS(NUM_SLOTS)) u_group (
        .decode_mask (dec_d),
        .brk_bits    (brk_bits),
        .mode        (mode),
        .group_start (grp_d)
    );

    pred_gate #(.NUM_SLOTS(NUM_SLOTS), .NUM_FLAGS(NUM_FLAGS)) u_pred (
        .flag_reg    (flag_reg),
        .flag_sel    (flag_sel),
        .sense       (sense),
        .pred_bits   (pred_bits),
        .decode_mask (dec_d),
        .exec_en     (exe_d)
    );

    always_comb begin
        ctl_d.dec = dec_d;
        ctl_d.grp = grp_d;
        ctl_d.exe = exe_d;
        ctl_d.alt = alt_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= hdr_valid;
            if (hdr_valid) ctl_q <= ctl_d;
        end
    end

    assign out_valid   = vld_q;
    assign decode_mask = ctl_q.dec;
    assign group_start = ctl_q.grp;
    assign exec_en     = ctl_q.exe;
    assign alt_out     = ctl_q.alt;

    // R1
    decode_count_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> ($countones(decode_mask) == NUM_SLOTS - int'($past(reserve_cnt))));

    // R2
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((group_start | exec_en) & ~decode_mask) == '0));

    // R4
    first_slot_group_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && decode_mask[0]) |-> group_start[0]);

    // R5
    seq_split_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && seq_mode) |=> (group_start == decode_mask));

    // R6
    unpred_enable_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> ((~$past(pred_bits) & decode_mask & ~exec_en) == '0));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> out_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !hdr_valid |=> (!out_valid && $stable(decode_mask) && $stable(exec_en)));

endmodule

// File: tb/vliw_hdr_ctl_bench.sv
module vliw_hdr_ctl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       hdr_valid, seq_mode, sense, alt_in;
    logic [6:0] brk_bits, pred_bits;
    logic [3:0] flag_sel;
    logic [2:0] reserve_cnt;
    logic [15:0] flag_reg;
    logic       out_valid, alt_out;
    logic [6:0] decode_mask, group_start, exec_en;

    int n_total = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    vliw_hdr_ctl u_vliw_hdr_ctl (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .seq_mode(seq_mode),
        .brk_bits(brk_bits), .pred_bits(pred_bits), .flag_sel(flag_sel),
        .sense(sense), .reserve_cnt(reserve_cnt), .alt_in(alt_in),
        .flag_reg(flag_reg), .out_valid(out_valid), .decode_mask(decode_mask),
        .group_start(group_start), .exec_en(exec_en), .alt_out(alt_out)
    );

    // {brk, pred, sel, sense, rsv, alt, seq, flags, exp_dec, exp_grp, exp_exe}
    localparam int NV = 10;
    localparam logic [60:0] TBL [NV] = '{
        {7'b0000000, 7'b0000000, 4'd0,  1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 7'b1111111, 7'b0000001, 7'b1111111},
        {7'b1010100, 7'b0000000, 4'd0,  1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 7'b1111111, 7'b1010101, 7'b1111111},
        {7'b1111110, 7'b0000000, 4'd0,  1'b0, 3'd3, 1'b1, 1'b0, 16'h0000, 7'b0001111, 7'b0001111, 7'b0001111},
        {7'b0000000, 7'b0000000, 4'd0,  1'b0, 3'd1, 1'b0, 1'b1, 16'h0000, 7'b0111111, 7'b0111111, 7'b0111111},
        {7'b0000000, 7'b0110011, 4'd5,  1'b0, 3'd0, 1'b0, 1'b0, 16'h0020, 7'b1111111, 7'b0000001, 7'b1111111},
        {7'b0000000, 7'b0110011, 4'd5,  1'b0, 3'd0, 1'b0, 1'b0, 16'hFFDF, 7'b1111111, 7'b0000001, 7'b1001100},
        {7'b1100000, 7'b1111111, 4'd15, 1'b1, 3'd2, 1'b1, 1'b0, 16'h7FFF, 7'b0011111, 7'b0000001, 7'b0011111},
        {7'b0000001, 7'b1010101, 4'd0,  1'b1, 3'd0, 1'b0, 1'b0, 16'h0001, 7'b1111111, 7'b0000001, 7'b0101010},
        {7'b1111111, 7'b0000000, 4'd0,  1'b0, 3'd7, 1'b0, 1'b1, 16'hFFFF, 7'b0000000, 7'b0000000, 7'b0000000},
        {7'b0000010, 7'b1000001, 4'd10, 1'b0, 3'd4, 1'b1, 1'b0, 16'h0400, 7'b0000111, 7'b0000011, 7'b0000111}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        hdr_valid = 0; seq_mode = 0; brk_bits = '0; pred_bits = '0;
        flag_sel = '0; sense = 0; reserve_cnt = '0; alt_in = 0; flag_reg = '0;
    endtask

    initial begin
        #20000;
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        drive_idle();
        rst = 1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 out_valid", 16'(out_valid), 16'd0);
        check("R10 decode_mask", 16'(decode_mask), 16'd0);
        check("R10 group_start/exec_en", 16'({group_start, exec_en}), 16'd0);
        check("R10 alt_out", 16'(alt_out), 16'd0);
        rst = 0;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            brk_bits    = TBL[v][60:54];
            pred_bits   = TBL[v][53:47];
            flag_sel    = TBL[v][46:43];
            sense       = TBL[v][42];
            reserve_cnt = TBL[v][41:39];
            alt_in      = TBL[v][38];
            seq_mode    = TBL[v][37];
            flag_reg    = TBL[v][36:21];
            hdr_valid   = 1;
            @(negedge clk);
            hdr_valid = 0;
            check("R9 out_valid", 16'(out_valid), 16'd1);
            check("R1 decode_mask", 16'(decode_mask), 16'(TBL[v][20:14]));
            check("R2/R3/R4/R5 group_start", 16'(group_start), 16'(TBL[v][13:7]));
            check("R2/R6/R7/R8 exec_en", 16'(exec_en), 16'(TBL[v][6:0]));
            check("R11 alt_out", 16'(alt_out), 16'(TBL[v][38]));
        end

        // R9: masks hold and out_valid stays low while no header arrives
        brk_bits = 7'b1111111; reserve_cnt = 3'd0; flag_reg = 16'hFFFF; alt_in = 0;
        repeat (3) @(negedge clk);
        check("R9 idle out_valid", 16'(out_valid), 16'd0);
        check("R9 idle decode_mask", 16'(decode_mask), 16'b0000111);
        check("R9 idle group_start", 16'(group_start), 16'b0000011);
        check("R11 idle alt_out", 16'(alt_out), 16'd1);

        // R3: slot 7 with break set, slot 1 without break still starts (R4)
        brk_bits = 7'b1000000; pred_bits = '0; reserve_cnt = 3'd0; seq_mode = 0;
        hdr_valid = 1;
        @(negedge clk);
        hdr_valid = 0;
        check("R3/R4 slot7 break", 16'(group_start), 16'b1000001);
        @(negedge clk);
        check("R9 single pulse", 16'(out_valid), 16'd0);

        // R10: reset after activity clears outputs
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R10 reset after use", 16'({decode_mask, group_start}), 16'd0);
        check("R10 reset exec/alt", 16'({exec_en, alt_out}), 16'd0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule